// File: doc/BRIEF.md
# Five-Port Tree Network Router Node

This block is one routing node of a tree-shaped on-chip network. It has five ports. Every port has an input side with its own small FIFO and an output side with a registered packet stage. A packet is a single word: a route field in the upper bits and a payload in the lower bits. The route field holds one 3-bit output-port code per hop, and the most significant code names the exit of the current node. The node removes that code and shifts the route left by one code. It then writes the index of the arrival port into the freed low code, so that the packet carries the way back. Each output's mux then passes the packet on toward the next node.

Links carry no ready or acknowledge signal. A neighbour pushes a packet whether or not there is room, and the input FIFOs are sized so that the supported traffic never fills them. If a write does land on a full FIFO, the packet is lost and a sticky per-port flag records the event. Requests and responses use opposite directions of the tree, so they never share a buffer. A packet may never leave by the port it came in on. Each output takes at most one packet per cycle. A round-robin arbiter resolves contention for an output, and the losing packets wait in their FIFOs. Outputs that are not in contention forward in the same cycle, so a node acts as one pipeline stage of the network.

Top module: `noc_router`

## Requirements
- R1: While reset is asserted and after its release with no input traffic, every `out_valid` bit and every `overflow` bit is 0.
- R2: A packet presented on input port p before rising edge k, whose route field has the exit code d in its top 3 bits (d in 0..4, d not equal to p), appears on output d with `out_valid[d]` high for exactly one cycle after rising edge k+1, provided no other packet contends for d.
- R3: The forwarded packet is laid out as {route, payload}. Its route is the incoming route shifted left by 3 bits, with the arriving port index p written into the lowest 3 bits, and its payload (the low DATA_W bits) is unchanged.
- R4: A packet whose exit code equals its arrival port, or is 5, 6 or 7, is discarded. No output raises `out_valid` for it.
- R5: After reset, input 0 has the highest priority at every output. After an output grants input g, input (g+1) mod 5 becomes the highest priority for that output. An output grants one packet per cycle, and the others stay queued.
- R6: Packets headed for distinct outputs in the same cycle are all forwarded in the same cycle.
- R7: Each input FIFO holds FIFO_DEPTH packets. A write into a full FIFO that is not being read in that cycle drops the packet and sets `overflow[p]`. That flag stays set until reset.
- R8: There is no back-pressure signal. Packets from one input port leave in the order they arrived.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 5 | Per-port packet strobe from the neighbours |
| in_data | input | 5*PKT_W | Packed input packets, port p at bits [p*PKT_W +: PKT_W] |
| out_valid | output | 5 | Per-port registered packet strobe to the neighbours |
| out_data | output | 5*PKT_W | Packed output packets, same packing as the input |
| overflow | output | 5 | Sticky per-input flag for a packet lost on a full FIFO |

## Verification
The bench builds the node with an 8-bit payload, four hops of route and a FIFO depth of four. This makes a packet 20 bits wide and small enough to sweep every arrival port against all eight exit codes, legal or not. The depth of four lets a flood of four inputs onto one output overflow every contending FIFO within a few cycles. A two-input burst of exactly four packets each shows that the full depth is usable without loss. With five ports, the bench can compute the complete round-robin order for any set of contenders and pointer position.

// File: rtl/noc_router_pkg.sv
package noc_router_pkg;
  localparam int unsigned PORT_CNT = 5;
  localparam int unsigned CODE_W   = 3;
endpackage

// File: rtl/nr_in_fifo.sv
module nr_in_fifo #(
  parameter int unsigned WIDTH = 20,
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty,
  output logic             overflow
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CW-1:0]    count_q, count_d;
  logic             ovf_q, ovf_d;
  logic             full, do_wr, do_rd;

  assign full  = (count_q == CW'(DEPTH));
  assign empty = (count_q == '0);
  assign do_rd = rd_en && !empty;
  assign do_wr = wr_en && (!full || do_rd);

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    count_d  = count_q;
    ovf_d    = ovf_q;
    if (do_wr) wr_ptr_d = (wr_ptr_q == AW'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
    if (do_rd) rd_ptr_d = (rd_ptr_q == AW'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
    if (do_wr && !do_rd) count_d = count_q + 1'b1;
    if (do_rd && !do_wr) count_d = count_q - 1'b1;
    if (wr_en && !do_wr) ovf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
      ovf_q    <= 1'b0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      count_q  <= count_d;
      ovf_q    <= ovf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem_q[wr_ptr_q] <= wr_data;
  end

  assign rd_data  = mem_q[rd_ptr_q];
  assign overflow = ovf_q;

  assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CW'(DEPTH));
  assert_overflow_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
endmodule

// File: rtl/nr_rr_arbiter.sv
module nr_rr_arbiter #(
  parameter int unsigned N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  localparam int unsigned PW = (N > 1) ? $clog2(N) : 1;

  logic [PW-1:0] ptr_q, ptr_d, win;
  logic          found;

  always_comb begin
    int idx;
    grant = '0;
    found = 1'b0;
    win   = '0;
    for (int i = 0; i < int'(N); i++) begin
      idx = int'(ptr_q) + i;
      if (idx >= int'(N)) idx = idx - int'(N);
      if (!found && req[idx]) begin
        found      = 1'b1;
        grant[idx] = 1'b1;
        win        = PW'(idx);
      end
    end
    ptr_d = ptr_q;
    if (found) ptr_d = (win == PW'(N - 1)) ? '0 : win + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assert_grant_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  assert_grant_requested_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~req) == '0);
  assert_grant_when_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |-> (|grant));
endmodule

// File: rtl/nr_out_stage.sv
module nr_out_stage #(
  parameter int unsigned N     = 5,
  parameter int unsigned WIDTH = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N-1:0]       sel,
  input  logic [N*WIDTH-1:0] cand,
  output logic               out_valid,
  output logic [WIDTH-1:0]   out_data
);
  logic             valid_q, valid_d;
  logic [WIDTH-1:0] data_q, data_d;

  always_comb begin
    valid_d = |sel;
    data_d  = '0;
    for (int p = 0; p < int'(N); p++) begin
      if (sel[p]) data_d = data_d | cand[p*WIDTH +: WIDTH];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (valid_d) data_q <= data_d;
  end

  assign out_valid = valid_q;
  assign out_data  = data_q;
endmodule

// File: rtl/noc_router.sv
module noc_router
  import noc_router_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned HOPS       = 4,
  parameter int unsigned FIFO_DEPTH = 4,
  localparam int unsigned ROUTE_W   = HOPS * CODE_W,
  localparam int unsigned PKT_W     = ROUTE_W + DATA_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [PORT_CNT-1:0]       in_valid,
  input  logic [PORT_CNT*PKT_W-1:0] in_data,
  output logic [PORT_CNT-1:0]       out_valid,
  output logic [PORT_CNT*PKT_W-1:0] out_data,
  output logic [PORT_CNT-1:0]       overflow
);
  logic [PKT_W-1:0]          head    [PORT_CNT];
  logic [CODE_W-1:0]         dest    [PORT_CNT];
  logic [PORT_CNT-1:0]       empty, legal, granted, pop;
  logic [PORT_CNT-1:0]       req_by_out   [PORT_CNT];
  logic [PORT_CNT-1:0]       grant_by_out [PORT_CNT];
  logic [PORT_CNT*PKT_W-1:0] cand;

  for (genvar p = 0; p < PORT_CNT; p++) begin : g_in
    nr_in_fifo #(.WIDTH(PKT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (in_valid[p]),
      .wr_data  (in_data[p*PKT_W +: PKT_W]),
      .rd_en    (pop[p]),
      .rd_data  (head[p]),
      .empty    (empty[p]),
      .overflow (overflow[p])
    );
    assign dest[p]  = head[p][PKT_W-1 -: CODE_W];
    assign legal[p] = (dest[p] < CODE_W'(PORT_CNT)) && (dest[p] != CODE_W'(p));
    assign pop[p]   = !empty[p] && (!legal[p] || granted[p]);
    assign cand[p*PKT_W +: PKT_W] =
      {head[p][PKT_W-CODE_W-1:DATA_W], CODE_W'(p), head[p][DATA_W-1:0]};

    assert_no_illegal_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!empty[p] && !legal[p]) |-> !granted[p]);
  end

  always_comb begin
    for (int o = 0; o < int'(PORT_CNT); o++) begin
      for (int p = 0; p < int'(PORT_CNT); p++) begin
        req_by_out[o][p] = !empty[p] && legal[p] && (dest[p] == CODE_W'(o));
      end
    end
    granted = '0;
    for (int o = 0; o < int'(PORT_CNT); o++) granted = granted | grant_by_out[o];
  end

  for (genvar o = 0; o < PORT_CNT; o++) begin : g_out
    nr_rr_arbiter #(.N(PORT_CNT)) u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (req_by_out[o]),
      .grant (grant_by_out[o])
    );
    nr_out_stage #(.N(PORT_CNT), .WIDTH(PKT_W)) u_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel       (grant_by_out[o]),
      .cand      (cand),
      .out_valid (out_valid[o]),
      .out_data  (out_data[o*PKT_W +: PKT_W])
    );

    assert_no_uturn_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[o] |-> (out_data[o*PKT_W + DATA_W +: CODE_W] != CODE_W'(o)));
  end
endmodule

// File: tb/noc_router_tb.sv
module noc_router_tb;
  localparam int P = 5;
  localparam int W = 20;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [P-1:0]   in_valid;
  logic [P*W-1:0] in_data;
  logic [P-1:0]   out_valid;
  logic [P*W-1:0] out_data;
  logic [P-1:0]   overflow;
  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  noc_router #(.DATA_W(8), .HOPS(4), .FIFO_DEPTH(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .overflow(overflow));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] pkt(input logic [11:0] route, input logic [7:0] pay);
    return {route, pay};
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; in_valid = '0; in_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // burst of packets to output o from inputs in mask; order lists expected winners
  task automatic burst(input logic [P-1:0] mask, input int o, input int n,
                       input logic [3:0][2:0] order, input string tag);
    for (int p = 0; p < P; p++) begin
      in_data[p*W +: W] = pkt({3'(o), 9'h0AB}, 8'(8'h40 + p));
    end
    in_valid = mask;
    @(negedge clk);
    in_valid = '0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      check({tag, " valid"}, 32'(out_valid), 32'(1 << o));
      check({tag, " winner"}, 32'(out_data[o*W +: 8]), 32'(8'h40 + order[k]));
    end
    @(negedge clk);
    check({tag, " idle"}, 32'(out_valid), 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = '0; in_data = '0;
    @(negedge clk);
    check("R1 valid in reset", 32'(out_valid), 32'h0);
    check("R1 overflow in reset", 32'(overflow), 32'h0);
    do_reset();
    check("R1 valid after reset", 32'(out_valid), 32'h0);
    check("R1 overflow after reset", 32'(overflow), 32'h0);

    // R2 R3 R4: sweep every arrival port against every exit code
    for (int p = 0; p < P; p++) begin
      for (int d = 0; d < 8; d++) begin
        logic [11:0] route;
        logic [7:0]  pay;
        route = {3'(d), 9'h1A5 ^ 9'(p * 8 + d)};
        pay   = 8'(p * 16 + d + 1);
        in_data[p*W +: W] = pkt(route, pay);
        in_valid = 5'(1 << p);
        @(negedge clk);
        in_valid = '0;
        check("R2 no output after one edge", 32'(out_valid), 32'h0);
        @(negedge clk);
        if (d < P && d != p) begin
          check("R2 output port", 32'(out_valid), 32'(1 << d));
          check("R3 forwarded packet", 32'(out_data[d*W +: W]),
                32'({route[8:0], 3'(p), pay}));
        end else begin
          check("R4 discarded packet", 32'(out_valid), 32'h0);
        end
        @(negedge clk);
        check("R2 single pulse", 32'(out_valid), 32'h0);
      end
    end
    check("R7 no overflow in sweep", 32'(overflow), 32'h0);

    // R5 round robin
    do_reset();
    burst(5'b11011, 2, 4, {3'd4, 3'd3, 3'd1, 3'd0}, "R5 from reset");
    burst(5'b11000, 2, 2, {3'd0, 3'd0, 3'd4, 3'd3}, "R5 pair");
    burst(5'b00010, 2, 1, {3'd0, 3'd0, 3'd0, 3'd1}, "R5 single");
    burst(5'b11011, 2, 4, {3'd1, 3'd0, 3'd4, 3'd3}, "R5 rotated");

    // R6 parallel forwarding to distinct outputs
    for (int p = 0; p < P; p++) begin
      in_data[p*W +: W] = pkt({3'((p + 1) % P), 9'h000}, 8'(8'h90 + p));
    end
    in_valid = 5'h1F;
    @(negedge clk);
    in_valid = '0;
    @(negedge clk);
    check("R6 all outputs at once", 32'(out_valid), 32'h1F);
    for (int p = 0; p < P; p++) begin
      check("R6 payload", 32'(out_data[((p + 1) % P)*W +: 8]), 32'(8'h90 + p));
    end
    @(negedge clk);

    // R7 R8: two inputs, four packets each, to output 0: full depth, no loss, in order
    begin
      int seen1 = 0, seen2 = 0;
      for (int k = 0; k < 4; k++) begin
        in_data[1*W +: W] = pkt({3'd0, 9'h0}, 8'(8'h10 + k));
        in_data[2*W +: W] = pkt({3'd0, 9'h0}, 8'(8'h20 + k));
        in_valid = 5'b00110;
        @(negedge clk);
        if (out_valid[0]) begin
          if (out_data[7:4] == 4'h1) begin check("R8 order in1", 32'(out_data[3:0]), 32'(seen1)); seen1++; end
          else begin check("R8 order in2", 32'(out_data[3:0]), 32'(seen2)); seen2++; end
        end
      end
      in_valid = '0;
      for (int k = 0; k < 12; k++) begin
        @(negedge clk);
        if (out_valid[0]) begin
          if (out_data[7:4] == 4'h1) begin check("R8 order in1", 32'(out_data[3:0]), 32'(seen1)); seen1++; end
          else begin check("R8 order in2", 32'(out_data[3:0]), 32'(seen2)); seen2++; end
        end
      end
      check("R7 all delivered in1", 32'(seen1), 32'd4);
      check("R7 all delivered in2", 32'(seen2), 32'd4);
      check("R7 no overflow at depth", 32'(overflow), 32'h0);
    end

    // R7 flood: four inputs push eight packets each at output 0
    for (int p = 1; p < P; p++) in_data[p*W +: W] = pkt({3'd0, 9'h0}, 8'(p));
    in_valid = 5'b11110;
    repeat (8) @(negedge clk);
    in_valid = '0;
    check("R7 overflow set", 32'(overflow), 32'h1E);
    repeat (40) @(negedge clk);
    check("R7 overflow sticky", 32'(overflow), 32'h1E);
    check("R7 drained", 32'(out_valid), 32'h0);
    do_reset();
    check("R1 overflow cleared by reset", 32'(overflow), 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule